// File: doc/BRIEF.md
# Two-Wire Serial Target with Broadcast Reset

This block is the serial front end of a register-programmed device that listens on a two-wire open-drain bus as a target. It samples the clock and data lines with the system clock, cleans them, and finds START, repeated START and STOP conditions. It then shifts in a 7-bit address and a direction bit and compares the address with a fixed six-bit prefix followed by one strap pin. When the address matches, it acknowledges and passes each following write byte to a register file as a one-cycle write strobe. The strobe carries the data and the byte's position in the transfer.

Two special first bytes are decoded. A broadcast address of all zeros, followed by the command byte 06h, produces a one-cycle reset pulse for the register file. A first byte whose upper five bits are 00001 announces a faster bus speed. The target does not acknowledge that byte, but it raises a speed flag that lasts until the next STOP. The block only ever pulls the data line low. It releases the line at all other times.

Top module: `i2c_gc_target`

## Requirements
- R1: A falling data line while the clock line is high is a START, and it returns the target to address reception from any state. A rising data line while the clock line is high is a STOP, and it returns the target to idle with the data line released.
- R2: Address and data bits are taken on the rising clock edge, most significant bit first. The eighth bit of the first byte is the direction bit, with 1 meaning read and 0 meaning write.
- R3: The target answers only to the 7-bit address formed by the 6-bit prefix 111010 followed by `strap_lsb`. With the default prefix this is 74h when the strap is low and 75h when the strap is high.
- R4: An acknowledge holds `sda_oe` high from the clock fall that ends the eighth bit until the clock fall that ends the ninth pulse. `sda_oe` is low during the eighth bit and after the ninth pulse.
- R5: After a matching write address, each received byte is acknowledged and produces a one-cycle `wr_en` pulse. The pulse comes with `wr_data` and with `wr_idx`, which is 0 for the first data byte after the address and counts up by one for each later byte.
- R6: A first byte that matches no accepted address is not acknowledged. The target then produces no acknowledge and no write until the next START.
- R7: A first byte of 00h is acknowledged. If the next byte is 06h, it is acknowledged and `gc_reset` pulses for exactly one cycle. Any other second byte is not acknowledged and produces no reset. No `wr_en` is produced in either case.
- R8: A first byte matching 00001xxx, where xxx is any value, is not acknowledged and sets `hs_mode`. `hs_mode` stays set across repeated STARTs and clears on STOP.
- R9: A repeated START in the middle of a byte discards the partial byte. The next byte is taken as a fresh address, and `wr_idx` restarts at 0.
- R10: A pulse on either line that is shorter than three filtered samples after the two-stage synchronizer is ignored, so it neither clocks a bit nor forms a condition.
- R11: A matching read address is acknowledged. After that the data line is released and no writes occur until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_lsb | input | 1 | Strap pin that sets the address LSB |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_idx | output | IDX_W | Byte position within the current write transfer |
| wr_data | output | 8 | Received data byte |
| gc_reset | output | 1 | One-cycle broadcast reset pulse |
| hs_mode | output | 1 | High-speed announcement seen since the last STOP |

## Verification
A wrong bit count or a wrong state shows up on the bus within one byte. It appears as an acknowledge that is missing, one that comes one pulse early or late, or one on an address that should be ignored. An address or command decode error shows up at the end of the first or second byte, as a missing or extra `wr_en` or `gc_reset` strobe. A speed flag or byte index that is not cleared correctly becomes visible at the next STOP or START. It shows as `hs_mode` staying high, or as `wr_idx` not starting at 0 on the first write that follows.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_DATA,
    ST_SKIP
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       clean <= 1'b1;
      else if (~|hist_q) clean <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    scl,
  input  logic    sda,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ev    <= '0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      ev.start <= scl & scl_q & sda_q & ~sda;
      ev.stop  <= scl & scl_q & ~sda_q & sda;
      ev.rise  <= scl & ~scl_q;
      ev.fall  <= ~scl & scl_q;
      ev.sda   <= sda;
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ev.start && ev.stop)); // R1
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         IDX_W       = 8,
  parameter logic [5:0] ADDR_PREFIX = 6'b111010
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_ev_t          ev,
  input  logic             strap_lsb,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             gc_reset,
  output logic             hs_mode
);
  tgt_state_e       state, ack_next;
  logic [2:0]       cnt;
  logic [6:0]       sh;
  logic             is_gc;
  logic [IDX_W-1:0] idx;
  logic [7:0]       byte_w;

  assign byte_w = {sh, ev.sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      is_gc    <= 1'b0;
      idx      <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      gc_reset <= 1'b0;
      hs_mode  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      gc_reset <= 1'b0;
      if (ev.stop) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (ev.start) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        idx    <= '0;
        is_gc  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (ev.rise) begin
            sh  <= byte_w[6:0];
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (byte_w[7:3] == HS_CODE_TOP) begin
                hs_mode <= 1'b1;
                state   <= ST_SKIP;
              end else if (byte_w == GC_ADDR_BYTE) begin
                is_gc    <= 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_DATA;
              end else if (byte_w[7:1] == {ADDR_PREFIX, strap_lsb}) begin
                state    <= ST_ACK;
                ack_next <= byte_w[0] ? ST_SKIP : ST_DATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: if (ev.fall) begin
            if (!sda_oe) begin
              sda_oe <= 1'b1;
            end else begin
              sda_oe <= 1'b0;
              state  <= ack_next;
              cnt    <= '0;
            end
          end
          ST_DATA: if (ev.rise) begin
            sh  <= byte_w[6:0];
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (is_gc) begin
                if (byte_w == GC_RESET_CMD) begin
                  gc_reset <= 1'b1;
                  state    <= ST_ACK;
                  ack_next <= ST_SKIP;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                wr_en    <= 1'b1;
                wr_data  <= byte_w;
                wr_idx   <= idx;
                idx      <= idx + 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_DATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ACK)); // R4
  AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(ev.fall | ev.start | ev.stop)); // R4
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R5
  AST_GC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(gc_reset && wr_en)); // R7
  AST_GC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    gc_reset |=> !gc_reset); // R7
  AST_HS_CLR_ON_STOP: assert property (@(posedge clk) disable iff (rst)
    ev.stop |=> !hs_mode); // R8
endmodule

// File: rtl/i2c_gc_target.sv
module i2c_gc_target
  import i2c_tgt_pkg::*;
#(
  parameter int         IDX_W       = 8,
  parameter logic [5:0] ADDR_PREFIX = 6'b111010,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             strap_lsb,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             gc_reset,
  output logic             hs_mode
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  bus_ev_t           ev;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_lines[i]),
      .clean(clean_lines[i])
    );
  end

  i2c_bus_events u_ev (
    .clk(clk),
    .rst(rst),
    .scl(clean_lines[0]),
    .sda(clean_lines[1]),
    .ev (ev)
  );

  i2c_tgt_fsm #(
    .IDX_W      (IDX_W),
    .ADDR_PREFIX(ADDR_PREFIX)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .strap_lsb(strap_lsb),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .gc_reset (gc_reset),
    .hs_mode  (hs_mode)
  );
endmodule

// File: tb/tb_i2c_gc_target.sv
`timescale 1ns/1ps
module tb_i2c_gc_target;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b0;
  logic       sda_oe, wr_en, gc_reset, hs_mode;
  logic [7:0] wr_idx, wr_data;
  wire        sda_bus = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  int gc_cnt = 0;
  logic [7:0] log_data [0:15];
  logic [7:0] log_idx  [0:15];

  always #2 clk = ~clk;

  i2c_gc_target dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_lsb(strap),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .gc_reset(gc_reset), .hs_mode(hs_mode)
  );

  always @(posedge clk) begin
    if (wr_en) begin
      log_data[wr_cnt[3:0]] <= wr_data;
      log_idx[wr_cnt[3:0]]  <= wr_idx;
      wr_cnt <= wr_cnt + 1;
    end
    if (gc_reset) gc_cnt <= gc_cnt + 1;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    if (glitch) begin
      scl_m = 1'b0; wq(2);
      scl_m = 1'b1; wq(Q-2);
    end else begin
      wq(Q);
    end
    scl_m = 1'b0;
  endtask

  // Sends a byte, returns ack seen on the bus and sda_oe at three phases.
  task automatic send_byte(input logic [7:0] b, input int glitch_bit,
                           output bit ack, output bit oe8, output bit oe_pre,
                           output bit oe_post);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      if (i == 0) oe8 = sda_oe;
      if (glitch_bit == i) begin
        scl_m = 1'b0; wq(2);
        scl_m = 1'b1; wq(Q-2);
      end else begin
        wq(Q);
      end
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(Q);
    oe_pre = sda_oe;
    scl_m = 1'b1; wq(Q);
    ack = ~sda_bus;
    wq(Q);
    scl_m = 1'b0; wq(Q);
    oe_post = sda_oe;
  endtask

  task automatic t_reset();
    check(!sda_oe && !wr_en && !gc_reset && !hs_mode, "R1 reset outputs idle",
          {sda_oe, wr_en, gc_reset, hs_mode}, 0);
  endtask

  task automatic t_addr(input bit s);
    bit a, o8, op, oq;
    strap = s;
    bus_start();
    send_byte(8'hE8, 99, a, o8, op, oq);
    bus_stop();
    check(a == !s, "R3 address 74h", a, !s);
    bus_start();
    send_byte(8'hEA, 99, a, o8, op, oq);
    bus_stop();
    check(a == s, "R3 address 75h", a, s);
    strap = 1'b0;
  endtask

  task automatic t_write();
    bit a, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'hE8, 99, a, o8, op, oq);
    check(!o8 && op && !oq, "R4 ack drive window", {o8, op, oq}, 3'b010);
    send_byte(8'hA5, 99, a, o8, op, oq);
    check(a, "R5 data byte 0 acked", a, 1);
    send_byte(8'h3C, 99, a, o8, op, oq);
    check(a, "R5 data byte 1 acked", a, 1);
    bus_stop();
    check(wr_cnt - base == 2, "R5 write count", wr_cnt - base, 2);
    check(log_data[base[3:0]] == 8'hA5 && log_idx[base[3:0]] == 0,
          "R2 R5 first write data/idx", {log_data[base[3:0]], log_idx[base[3:0]]}, 16'hA500);
    check(log_data[base[3:0]+1] == 8'h3C && log_idx[base[3:0]+1] == 1,
          "R5 second write data/idx", {log_data[base[3:0]+1], log_idx[base[3:0]+1]}, 16'h3C01);
    check(!sda_oe, "R1 released after STOP", sda_oe, 0);
  endtask

  task automatic t_gc();
    bit a1, a2, o8, op, oq;
    int wb = wr_cnt;
    int gb = gc_cnt;
    bus_start();
    send_byte(8'h00, 99, a1, o8, op, oq);
    send_byte(8'h06, 99, a2, o8, op, oq);
    bus_stop();
    check(a1 && a2, "R7 general call acked", {a1, a2}, 3);
    check(gc_cnt - gb == 1, "R7 one reset pulse", gc_cnt - gb, 1);
    bus_start();
    send_byte(8'h00, 99, a1, o8, op, oq);
    send_byte(8'h05, 99, a2, o8, op, oq);
    bus_stop();
    check(a1 && !a2, "R7 wrong command not acked", {a1, a2}, 2);
    check(gc_cnt - gb == 1 && wr_cnt == wb, "R7 no reset no write",
          gc_cnt - gb + 16 * (wr_cnt - wb), 1);
  endtask

  task automatic t_hs();
    bit a, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'h0B, 99, a, o8, op, oq);
    check(!a && hs_mode, "R8 hs code not acked, flag set", {a, hs_mode}, 1);
    bus_start();
    wq(Q);
    check(hs_mode, "R8 flag kept over repeated START", hs_mode, 1);
    send_byte(8'hE8, 99, a, o8, op, oq);
    check(a, "R8 address acked in hs mode", a, 1);
    send_byte(8'h11, 99, a, o8, op, oq);
    bus_stop();
    check(!hs_mode, "R8 flag cleared by STOP", hs_mode, 0);
    check(wr_cnt - base == 1 && log_idx[base[3:0]] == 0, "R5 idx after hs",
          wr_cnt - base, 1);
  endtask

  task automatic t_abort();
    bit a, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'hE8, 99, a, o8, op, oq);
    send_byte(8'h77, 99, a, o8, op, oq);
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    bus_start();
    send_byte(8'hE8, 99, a, o8, op, oq);
    check(a, "R9 address after abort acked", a, 1);
    send_byte(8'h5A, 99, a, o8, op, oq);
    bus_stop();
    check(wr_cnt - base == 2, "R9 partial byte discarded", wr_cnt - base, 2);
    check(log_data[base[3:0]+1] == 8'h5A && log_idx[base[3:0]+1] == 0,
          "R9 idx restarts", {log_data[base[3:0]+1], log_idx[base[3:0]+1]}, 16'h5A00);
  endtask

  task automatic t_nomatch();
    bit a1, a2, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'hD0, 99, a1, o8, op, oq);
    send_byte(8'hE8, 99, a2, o8, op, oq);
    bus_stop();
    check(!a1 && !a2 && wr_cnt == base, "R6 foreign address ignored",
          {a1, a2}, 0);
  endtask

  task automatic t_read();
    bit a, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'hE9, 99, a, o8, op, oq);
    check(a && !oq, "R11 read address acked then released", {a, oq}, 2);
    send_byte(8'h00, 99, a, o8, op, oq);
    bus_stop();
    check(!a && wr_cnt == base, "R11 no writes in read", wr_cnt - base, 0);
  endtask

  task automatic t_glitch();
    bit a, o8, op, oq;
    int base = wr_cnt;
    bus_start();
    send_byte(8'hE8, 3, a, o8, op, oq);
    check(a, "R10 glitch on SCL ignored in address", a, 1);
    send_byte(8'hC3, 5, a, o8, op, oq);
    bus_stop();
    check(wr_cnt - base == 1 && log_data[base[3:0]] == 8'hC3,
          "R10 data intact with glitch", log_data[base[3:0]], 8'hC3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wq(5);
    rst = 1'b0;
    wq(Q);
    t_reset();
    t_addr(1'b0);
    t_addr(1'b1);
    t_write();
    t_gc();
    t_hs();
    t_abort();
    t_nomatch();
    t_read();
    t_glitch();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule